// File: doc/BRIEF.md
# Backpressure false carrier generator

This block gives a half-duplex MAC port a way to slow down the stations that send to it. A congestion input comes from the receive buffer logic, which raises it when the buffer crosses its threshold. While that input is high, the block waits for the shared medium to go quiet. It then waits a further 44 bit times of unbroken silence, which is eleven transmit clock cycles on the nibble-wide MII. After that it drives transmit enable high with a fixed alternating-bit nibble. Remote stations see carrier and defer, and nothing valid reaches the port. When congestion clears, the block ends the current nibble and releases the transmit pins.

A real frame from the local MAC takes precedence. If the MAC reports a pending frame at the moment the idle gap completes, the block gives up that gap. It does not start a jam again until carrier has been seen once more, because the MAC's own frame raises carrier. Each jam is followed by a new full idle gap before another jam may begin.

Top module: `bp_fcs_gen`

## Requirements
- R1: After reset, tx_en_o is 0 and txd_o is 4'b0000.
- R2: While congest_i is low, tx_en_o never rises.
- R3: tx_en_o rises only on an edge that follows GAP_CYC (11) consecutive edges at which crs_i was sampled low. Any high sample restarts the count. With congest_i held high, tx_en_o is high on the 12th edge after crs_i falls.
- R4: While tx_en_o is high, txd_o is 4'b0101 on every cycle. Bit 0 is the first bit on the line.
- R5: Once started, the jam continues for as long as congest_i stays high, regardless of crs_i.
- R6: On the first edge at which congest_i is sampled low during a jam, tx_en_o falls and txd_o returns to 4'b0000.
- R7: If pend_i is high at an edge where the idle gap is complete, no jam starts at that edge. No jam starts at any later edge until crs_i has been sampled high.
- R8: After a jam ends, a full new gap of GAP_CYC idle edges is required before the next jam. The count starts on the edge after tx_en_o falls.
- R9: While tx_en_o is low, txd_o is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | MII transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| congest_i | input | 1 | Backpressure request from the buffer threshold logic |
| crs_i | input | 1 | MII carrier sense, synchronous to clk_i |
| pend_i | input | 1 | Local MAC has a real frame waiting to send |
| tx_en_o | output | 1 | MII transmit enable, high during a false carrier |
| txd_o | output | 4 | MII transmit nibble |

## Verification
The hardest case to reach is the yield path. A frame must become pending on exactly the edge where the idle gap completes while congestion is high. The block must then stay silent through arbitrary further idle time until carrier returns. Directed steps hold carrier low for exactly the gap length and then raise pend_i. They also cover carrier glitches one cycle before gap completion and a congestion drop directly after a jam begins. Randomized traffic with short carrier bursts and sparse pend_i then reaches the remaining cases against a cycle model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned NIB_W = 4;
  localparam logic [NIB_W-1:0] JAM_NIB = 4'b0101;
  typedef enum logic [1:0] {
    ST_QUIET = 2'd0,
    ST_YIELD = 2'd1,
    ST_JAM   = 2'd2
  } bp_state_e;
endpackage

// File: rtl/bp_idle_timer.sv
module bp_idle_timer #(
  parameter int unsigned GAP_CYC = 11,
  localparam int unsigned CNT_W = $clog2(GAP_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic gap_done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (cnt_q != CNT_W'(GAP_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign gap_done_o = (cnt_q == CNT_W'(GAP_CYC));
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic congest_i,
  input  logic crs_i,
  input  logic pend_i,
  input  logic gap_done_i,
  output logic jam_o,
  output logic timer_clr_o
);
  bp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_QUIET: begin
        if (gap_done_i && !crs_i) begin
          if (pend_i)         st_d = ST_YIELD;
          else if (congest_i) st_d = ST_JAM;
        end
      end
      ST_YIELD: if (crs_i) st_d = ST_QUIET;
      ST_JAM:   if (!congest_i) st_d = ST_QUIET;
      default:  st_d = ST_QUIET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_QUIET;
    else         st_q <= st_d;
  end

  assign jam_o       = (st_q == ST_JAM);
  // own carrier counts as busy medium
  assign timer_clr_o = crs_i || jam_o;
endmodule

// File: rtl/bp_tx_drv.sv
module bp_tx_drv
  import bp_pkg::*;
(
  input  logic             jam_i,
  output logic             tx_en_o,
  output logic [NIB_W-1:0] txd_o
);
  assign tx_en_o = jam_i;
  assign txd_o   = jam_i ? JAM_NIB : '0;
endmodule

// File: rtl/bp_fcs_gen.sv
module bp_fcs_gen #(
  parameter int unsigned GAP_BITS = 44,
  localparam int unsigned GAP_CYC = GAP_BITS / bp_pkg::NIB_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       congest_i,
  input  logic       crs_i,
  input  logic       pend_i,
  output logic       tx_en_o,
  output logic [3:0] txd_o
);
  logic gap_done, jam, timer_clr;

  bp_idle_timer #(.GAP_CYC(GAP_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(timer_clr), .gap_done_o(gap_done)
  );

  bp_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .congest_i(congest_i), .crs_i(crs_i),
    .pend_i(pend_i), .gap_done_i(gap_done), .jam_o(jam), .timer_clr_o(timer_clr)
  );

  bp_tx_drv u_drv (.jam_i(jam), .tx_en_o(tx_en_o), .txd_o(txd_o));
endmodule

// File: rtl/bp_fcs_gen_chk.sv
module bp_fcs_gen_chk #(
  parameter int unsigned GAP_CYC = 11,
  localparam int unsigned CW = $clog2(GAP_CYC + 1)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       congest_i,
  input logic       crs_i,
  input logic       pend_i,
  input logic       tx_en_o,
  input logic [3:0] txd_o
);
  logic [CW-1:0] run_q;
  logic          hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= '0;
    else if (crs_i || tx_en_o)        run_q <= '0;
    else if (run_q != CW'(GAP_CYC))   run_q <= run_q + 1'b1;
  end

  // set when a pending frame claims a completed gap, cleared by carrier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= 1'b0;
    else if (crs_i) hold_q <= 1'b0;
    else if (!tx_en_o && pend_i && run_q == CW'(GAP_CYC)) hold_q <= 1'b1;
  end

  AST_NO_JAM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !congest_i |=> !tx_en_o); // R2
  AST_GAP_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> ($past(run_q) == CW'(GAP_CYC) && !$past(crs_i))); // R3
  AST_JAM_PAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> txd_o == 4'b0101); // R4
  AST_JAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && congest_i) |=> tx_en_o); // R5
  AST_JAM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && !congest_i) |=> !tx_en_o); // R6
  AST_YIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> (!$past(pend_i) && !$past(hold_q))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> txd_o == 4'b0000); // R9
endmodule

bind bp_fcs_gen bp_fcs_gen_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .congest_i(congest_i), .crs_i(crs_i),
  .pend_i(pend_i), .tx_en_o(tx_en_o), .txd_o(txd_o)
);

// File: tb/bp_fcs_gen_test.sv
`timescale 1ns/1ps
module bp_fcs_gen_test;
  localparam int GAP = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic congest = 1'b0, crs = 1'b0, pend = 1'b0;
  logic tx_en;
  logic [3:0] txd;

  int total = 0, bad = 0;
  bit done_f = 1'b0;

  int  m_cnt = 0;
  bit  m_jam = 1'b0, m_yield = 1'b0, m_prev = 1'b0;

  always #4 clk = ~clk;

  bp_fcs_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .congest_i(congest), .crs_i(crs),
    .pend_i(pend), .tx_en_o(tx_en), .txd_o(txd)
  );

  function automatic logic [3:0] exp_txd(bit j);
    return j ? 4'b0101 : 4'b0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_jam = 0; m_yield = 0; m_prev = 0;
    end else begin
      bit nj, ny; int nc;
      m_prev = m_jam;
      nj = m_jam ? congest : (congest && m_cnt == GAP && !crs && !pend && !m_yield);
      ny = crs ? 1'b0 : ((m_cnt == GAP && pend && !m_jam && !m_yield) ? 1'b1 : m_yield);
      nc = (crs || m_jam) ? 0 : (m_cnt == GAP ? GAP : m_cnt + 1);
      m_jam = nj; m_yield = ny; m_cnt = nc;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_f) begin
      string r;
      if (m_jam)        r = "R4";
      else if (m_prev)  r = "R6";
      else if (m_yield) r = "R7";
      else if (!congest) r = "R2";
      else              r = "R3";
      chk(r, {31'd0, tx_en}, {31'd0, m_jam});
      chk(m_jam ? "R4" : "R9", {28'd0, txd}, {28'd0, exp_txd(m_jam)});
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    int lat;
    void'($urandom(32'h5EED_0042));
    cyc(3);
    chk("R1", {31'd0, tx_en}, 32'd0);
    chk("R1", {28'd0, txd}, 32'd0);
    rst_n = 1'b1;
    cyc(2);

    // R3: latency after carrier drop
    crs = 1'b1; congest = 1'b1; cyc(5);
    crs = 1'b0; lat = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); lat++; if (tx_en) break; end
    chk("R3", lat, GAP + 1);
    // R5: carrier during jam ignored
    crs = 1'b1; cyc(4); chk("R5", {31'd0, tx_en}, 32'd1); crs = 1'b0;
    // R6: stop after one sample of congest low
    congest = 1'b0; cyc(1); chk("R6", {31'd0, tx_en}, 32'd0);
    // R8: fresh gap after jam
    congest = 1'b1; lat = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); lat++; if (tx_en) break; end
    chk("R8", lat, GAP + 1);
    congest = 1'b0; cyc(1);

    // R3: glitch one cycle before gap completion restarts the count
    crs = 1'b1; cyc(2); crs = 1'b0; congest = 1'b1; cyc(GAP - 1);
    crs = 1'b1; cyc(1); crs = 1'b0; cyc(GAP);
    chk("R3", {31'd0, tx_en}, 32'd0);
    cyc(1); chk("R3", {31'd0, tx_en}, 32'd1);
    congest = 1'b0; cyc(1);

    // R7: pending frame claims the gap
    crs = 1'b1; cyc(1); crs = 1'b0; congest = 1'b1; cyc(GAP);
    pend = 1'b1; cyc(1); pend = 1'b0; cyc(20);
    chk("R7", {31'd0, tx_en}, 32'd0);
    crs = 1'b1; cyc(3); crs = 1'b0; cyc(GAP + 1);
    chk("R7", {31'd0, tx_en}, 32'd1);
    congest = 1'b0; cyc(2);

    // R2: long idle without congestion
    cyc(40); chk("R2", {31'd0, tx_en}, 32'd0);

    // randomized traffic against the model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 39) == 0) congest = ~congest;
      if (crs) crs = ($urandom_range(0, 3) != 0);
      else     crs = ($urandom_range(0, 24) == 0);
      pend = ($urandom_range(0, 29) == 0);
      cyc(1);
    end
    finish_run();
  end
endmodule